// File: doc/BRIEF.md
# SPI Register Access Master with Optional CRC-8 Trailer

This block sits on the host side of a serial peripheral link. Each call reads or writes one 24-bit register in a remote device. A local request carries four things: a 7-bit register address, a read/write flag, the write data and a CRC switch. The block then runs one complete serial frame on SCLK, MOSI, MISO and an active-low chip select.

Every frame starts with a command byte that holds the address and the direction. Twenty-four data bits follow. When the CRC switch is on, an eighth-bit-wide check byte comes last. On writes the block computes that byte and sends it. On reads the peripheral supplies it, and the block compares it with its own CRC over the command byte it sent and the data it received.

The link uses clock polarity 0 and phase 0. The system clock is divided by an even parameter to make SCLK. A busy flag covers the whole frame and the chip-select recovery time that follows it. A one-cycle done pulse ends each frame. On a read, that pulse also delivers the read data and the CRC verdict.

Top module: `spi_reg_master`

## Requirements
- R1: A frame has exactly 32 SCLK rising edges when the CRC switch is off and 40 when it is on.
- R2: The first byte sent is {address[6:0], dir}, where dir = 1 means read and dir = 0 means write. Write data follows it, most significant bit first. On reads, MOSI carries zeros after the command byte.
- R3: SCLK idles low, has a period of CLK_DIV system clocks and a 50% duty cycle. MOSI changes only in the cycle SCLK falls, or while chip select is high. The first bit is valid CLK_DIV/2 cycles before the first rising edge.
- R4: On a write with CRC on, the trailer byte is CRC-8 over the command byte and then the three data bytes, high byte first. The polynomial is x^8+x^2+x+1 (0x07), the initial value 0x00, the bit order MSB first, and there is no final XOR. The byte is sent right after the data.
- R5: Chip select falls CLK_DIV/2 cycles before the first rising edge and rises CLK_DIV/2 cycles after the last falling edge. SCLK never toggles while chip select is high. After reset, chip select is high and SCLK is low.
- R6: On a read, rdata shows the 24 bits received after the command byte, first bit received in bit 23. It is valid in the done cycle.
- R7: On a read with CRC on, the received trailer is compared with a CRC-8 (as in R4) over the sent command byte and the three received data bytes. A mismatch sets crc_err in the done cycle, and rdata is still updated.
- R8: crc_err keeps its value until the next request is accepted, then clears. It is never set by a write or by a read with CRC off, and it is low after reset.
- R9: busy goes high the cycle after a request is accepted and falls in the single cycle in which done pulses. A request while busy is ignored: it starts no frame and changes no register.
- R10: Between two frames, chip select stays high for at least CLK_DIV system clocks, including back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a register access, taken when not busy |
| req_addr | input | ADDR_W | Register address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | DATA_W | Data for a write |
| req_crc_en | input | 1 | Append/check the CRC-8 trailer byte |
| busy | output | 1 | Frame or chip-select recovery in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Data from the last read |
| crc_err | output | 1 | Read trailer mismatch, held until the next accepted request |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench models the peripheral as a register file that decodes each frame, answers reads and checks write trailers. It goes after the CRC insertion point and address 0x7F with all-ones data. A design that folded the trailer in one bit late, or mixed up the direction bit, would corrupt the frame or write the wrong register. A read with a deliberately corrupted trailer must raise crc_err, still deliver the data, and hold the flag through idle cycles until the next acceptance. A design that dropped the data or cleared the flag early would show it directly. A request pulsed in the middle of a frame must leave both the frame count and the target register untouched. Back-to-back requests measure the chip-select recovery time, which a design that released busy at the last SCLK edge would cut short.

// File: rtl/srm_pkg.sv
package srm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_TAIL,
      ST_GAP
   } srm_state_t;
endpackage

// File: rtl/srm_sclk_tick.sv
// Half-period strobe generator: tick every HALF system clocks while run is high.
module srm_sclk_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/srm_crc8.sv
// Bit-serial CRC-8, MSB first, polynomial chosen by parameter.
module srm_crc8 #(
   parameter logic [7:0] POLY = 8'h07,
   parameter logic [7:0] INIT = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       din,
   output logic [7:0] crc
);
   logic       fb;
   logic [7:0] nxt;

   assign fb = crc[7] ^ din;

   for (genvar i = 0; i < 8; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = fb & POLY[i];
      end else begin : g_up
         assign nxt[i] = crc[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= INIT;
      else if (clr)
         crc <= INIT;
      else if (en)
         crc <= nxt;
   end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
   import srm_pkg::*;
#(
   parameter int         CLK_DIV  = 4,
   parameter int         ADDR_W   = 7,
   parameter int         DATA_W   = 24,
   parameter logic [7:0] CRC_POLY = 8'h07,
   parameter logic [7:0] CRC_INIT = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_rd,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_crc_en,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              crc_err,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso
);
   localparam int HALF   = CLK_DIV / 2;
   localparam int CMD_W  = ADDR_W + 1;
   localparam int BASE_W = CMD_W + DATA_W;
   localparam int FULL_W = BASE_W + 8;
   localparam int RX_W   = DATA_W + 8;
   localparam int IDX_W  = $clog2(FULL_W);

   localparam logic [IDX_W-1:0] IDX_CMD_END   = IDX_W'(CMD_W);
   localparam logic [IDX_W-1:0] IDX_BASE      = IDX_W'(BASE_W);
   localparam logic [IDX_W-1:0] IDX_BASE_LAST = IDX_W'(BASE_W - 1);
   localparam logic [IDX_W-1:0] IDX_FULL_LAST = IDX_W'(FULL_W - 1);

   // elaboration-time parameter checks
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be an even number of at least 2");
   end
   if ((CMD_W % 8) != 0 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("command and data fields must be whole bytes");
   end

   srm_state_t           state;
   logic                 sclk_q;
   logic                 cs_q;
   logic [FULL_W-1:0]    tx;
   logic [FULL_W-1:0]    tx_next;
   logic [RX_W-1:0]      rx;
   logic [IDX_W-1:0]     idx;
   logic [IDX_W-1:0]     last_idx;
   logic                 crc_on;
   logic                 rd_q;
   logic                 gap_half;
   logic                 done_q;
   logic                 err_q;
   logic [DATA_W-1:0]    rdata_q;

   logic                 run;
   logic                 tick;
   logic                 accept;
   logic                 rise;
   logic                 fall;
   logic                 crc_step;
   logic                 crc_bit;
   logic [7:0]           crc_val;
   logic [DATA_W-1:0]    rx_data;

   assign run    = (state != ST_IDLE);
   assign accept = req && (state == ST_IDLE);

   srm_sclk_tick #(.HALF(HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   assign rise     = tick && ((state == ST_LEAD) || (state == ST_XFER && !sclk_q));
   assign fall     = tick && (state == ST_XFER) && sclk_q;
   assign crc_step = rise && (idx < IDX_BASE);
   assign crc_bit  = (idx < IDX_CMD_END || !rd_q) ? tx[FULL_W-1] : miso;
   assign last_idx = crc_on ? IDX_FULL_LAST : IDX_BASE_LAST;

   srm_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (accept),
      .en   (crc_step),
      .din  (crc_bit),
      .crc  (crc_val)
   );

   // next transmit word: shift, and splice the trailer in behind the data on writes
   always_comb begin
      tx_next = {tx[FULL_W-2:0], 1'b0};
      if (!rd_q && crc_on && idx == IDX_BASE_LAST)
         tx_next[FULL_W-1 -: 8] = crc_val;
   end

   assign rx_data = crc_on ? rx[RX_W-1 -: DATA_W] : rx[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sclk_q   <= 1'b0;
         cs_q     <= 1'b1;
         tx       <= '0;
         rx       <= '0;
         idx      <= '0;
         crc_on   <= 1'b0;
         rd_q     <= 1'b0;
         gap_half <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  tx     <= {req_addr, req_rd, (req_rd ? {DATA_W{1'b0}} : req_wdata), 8'h00};
                  rx     <= '0;
                  idx    <= '0;
                  crc_on <= req_crc_en;
                  rd_q   <= req_rd;
                  cs_q   <= 1'b0;
                  err_q  <= 1'b0;
                  state  <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (rise) begin
                  sclk_q <= 1'b1;
                  rx     <= {rx[RX_W-2:0], miso};
                  state  <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (rise) begin
                  sclk_q <= 1'b1;
                  rx     <= {rx[RX_W-2:0], miso};
               end else if (fall) begin
                  sclk_q <= 1'b0;
                  if (idx == last_idx) begin
                     state <= ST_TAIL;
                  end else begin
                     idx <= idx + 1'b1;
                     tx  <= tx_next;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_q     <= 1'b1;
                  gap_half <= 1'b0;
                  state    <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_half) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     if (rd_q) begin
                        rdata_q <= rx_data;
                        err_q   <= crc_on && (rx[7:0] != crc_val);
                     end
                  end else begin
                     gap_half <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = run;
   assign done    = done_q;
   assign rdata   = rdata_q;
   assign crc_err = err_q;
   assign sclk    = sclk_q;
   assign cs_n    = cs_q;
   assign mosi    = tx[FULL_W-1];
endmodule

// File: rtl/srm_chk.sv
module srm_chk #(
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 24
) (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic busy,
   input logic done,
   input logic crc_err,
   input logic sclk,
   input logic mosi,
   input logic cs_n
);
   localparam int SHORT_LEN = ADDR_W + 1 + DATA_W;
   localparam int LONG_LEN  = SHORT_LEN + 8;

   int   gap_cnt;
   int   rise_cnt;
   logic sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt  <= CLK_DIV;
         rise_cnt <= 0;
         sclk_d   <= 1'b0;
      end else begin
         sclk_d <= sclk;
         if (cs_n)
            gap_cnt <= (gap_cnt < CLK_DIV) ? gap_cnt + 1 : gap_cnt;
         else
            gap_cnt <= 0;
         if (cs_n)
            rise_cnt <= 0;
         else if (sclk && !sclk_d)
            rise_cnt <= rise_cnt + 1;
      end
   end

   assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_cnt == SHORT_LEN || rise_cnt == LONG_LEN));

   assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n) && !$fell(sclk)) |-> $stable(mosi));

   assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_err) |-> (done || $past(req && !busy)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (gap_cnt >= CLK_DIV));
endmodule

bind spi_reg_master srm_chk #(
   .CLK_DIV(CLK_DIV),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_srm_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req    (req),
   .busy   (busy),
   .done   (done),
   .crc_err(crc_err),
   .sclk   (sclk),
   .mosi   (mosi),
   .cs_n   (cs_n)
);

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int HALF       = DIV / 2;

   logic        clk;
   logic        rst_n;
   logic        req;
   logic [6:0]  req_addr;
   logic        req_rd;
   logic [23:0] req_wdata;
   logic        req_crc_en;
   logic        busy;
   logic        done;
   logic [23:0] rdata;
   logic        crc_err;
   logic        sclk;
   logic        mosi;
   logic        cs_n;
   logic        miso;

   spi_reg_master #(.CLK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_rd(req_rd),
      .req_wdata(req_wdata), .req_crc_en(req_crc_en), .busy(busy), .done(done),
      .rdata(rdata), .crc_err(crc_err), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .miso(miso)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int total = 0;
   int bad   = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference CRC-8, byte at a time
   function automatic logic [7:0] ref_crc(input logic [31:0] msg);
      logic [7:0] c;
      c = 8'h00;
      for (int b = 3; b >= 0; b--) begin
         c = c ^ msg[b*8 +: 8];
         for (int k = 0; k < 8; k++)
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [23:0] init_val(input int a);
      return 24'(a * 24'h010203) ^ 24'h5A5A5A;
   endfunction

   // peripheral model and per-clock link monitor
   logic [23:0] mem [0:127];
   int          s_cnt, since, frames, last_len, gap_run, gap_min;
   int          half_bad, mosi_bad, idle_clk_bad, wr_crc_bad;
   logic [39:0] s_frame, s_resp, last_frame;
   logic        prev_sclk, prev_cs, prev_mosi, corrupt;

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = init_val(i);
      s_cnt = 0; since = 0; frames = 0; last_len = 0; gap_run = 0; gap_min = 1000;
      half_bad = 0; mosi_bad = 0; idle_clk_bad = 0; wr_crc_bad = 0;
      s_frame = '0; s_resp = '0; last_frame = '0;
      prev_sclk = 1'b0; prev_cs = 1'b1; prev_mosi = 1'b0; corrupt = 1'b0;
      miso = 1'b0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n && sclk) idle_clk_bad++;
         if (prev_cs && !cs_n) begin
            if (frames > 0 && gap_run < gap_min) gap_min = gap_run;
            s_cnt = 0; s_frame = '0; s_resp = '0; since = 0; miso = 1'b0;
         end else if (!cs_n) begin
            since++;
            if (mosi !== prev_mosi && !(prev_sclk && !sclk)) mosi_bad++;
            if (sclk && !prev_sclk) begin
               if (since != HALF) half_bad++;
               since = 0;
               s_frame = {s_frame[38:0], mosi};
               s_cnt++;
            end else if (!sclk && prev_sclk) begin
               if (since != HALF) half_bad++;
               since = 0;
               if (s_cnt == 8 && s_frame[0])
                  s_resp = {s_frame[7:0], mem[s_frame[7:1]],
                            ref_crc({s_frame[7:0], mem[s_frame[7:1]]}) ^ (corrupt ? 8'h01 : 8'h00)};
               miso = (s_cnt < 40) ? s_resp[39 - s_cnt] : 1'b0;
            end
         end else if (!prev_cs && cs_n) begin
            logic [7:0]  cmd;
            logic [23:0] dat;
            if (since + 1 != HALF) half_bad++;
            frames++;
            last_len   = s_cnt;
            last_frame = s_frame;
            cmd = (s_cnt == 40) ? s_frame[39:32] : s_frame[31:24];
            dat = (s_cnt == 40) ? s_frame[31:8]  : s_frame[23:0];
            if (!cmd[0]) begin
               mem[cmd[7:1]] = dat;
               if (s_cnt == 40 && s_frame[7:0] != ref_crc({cmd, dat})) wr_crc_bad++;
            end
            gap_run = 0;
         end
         if (cs_n) gap_run++;
         prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
      end
   end

   // one access; returns at the negedge where done is seen
   task automatic txn(input logic [6:0] a, input logic rd, input logic [23:0] wd,
                      input logic ce, output logic [23:0] rv, output logic ev,
                      output logic busy_after, output logic err_after);
      while (busy) @(negedge clk);
      req_addr = a; req_rd = rd; req_wdata = wd; req_crc_en = ce; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      busy_after = busy;
      err_after  = crc_err;
      while (!done) @(negedge clk);
      rv = rdata;
      ev = crc_err;
   endtask

   logic [23:0] rv;
   logic        ev, bz, ea;
   int          fr0;
   bit          finished = 0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; req_addr = '0; req_rd = 1'b0; req_wdata = '0; req_crc_en = 1'b0;
      repeat (5) @(negedge clk);
      chk("R5 reset cs_n", cs_n, 1);
      chk("R5 reset sclk", sclk, 0);
      chk("R9 reset busy", busy, 0);
      chk("R9 reset done", done, 0);
      chk("R8 reset crc_err", crc_err, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // plain write
      txn(7'h12, 1'b0, 24'h3C5A96, 1'b0, rv, ev, bz, ea);
      chk("R9 busy after accept", bz, 1);
      chk("R9 busy low at done", busy, 0);
      @(negedge clk);
      chk("R9 done single cycle", done, 0);
      chk("R1 length no crc", last_len, 32);
      chk("R2 write frame", last_frame[31:0], {8'h24, 24'h3C5A96});

      // write with trailer at top address, all ones
      txn(7'h7F, 1'b0, 24'hFFFFFF, 1'b1, rv, ev, bz, ea);
      chk("R1 length with crc", last_len, 40);
      chk("R4 write trailer", last_frame, {8'hFE, 24'hFFFFFF, ref_crc({8'hFE, 24'hFFFFFF})});
      chk("R8 no error on write", ev, 0);

      // plain read back
      txn(7'h12, 1'b1, 24'hABCDEF, 1'b0, rv, ev, bz, ea);
      chk("R6 read data", rv, 24'h3C5A96);
      chk("R2 read command and zero fill", last_frame[31:0], {8'h25, 24'h000000});
      chk("R8 no error crc off", ev, 0);

      // read with good trailer
      txn(7'h7F, 1'b1, 24'h0, 1'b1, rv, ev, bz, ea);
      chk("R7 read data crc on", rv, 24'hFFFFFF);
      chk("R7 good trailer", ev, 0);

      // read with corrupted trailer
      corrupt = 1'b1;
      txn(7'h00, 1'b1, 24'h0, 1'b1, rv, ev, bz, ea);
      chk("R7 bad trailer flagged", ev, 1);
      chk("R7 data kept on bad trailer", rv, init_val(0));
      corrupt = 1'b0;
      repeat (25) @(negedge clk);
      chk("R8 error held while idle", crc_err, 1);
      txn(7'h03, 1'b0, 24'h000111, 1'b1, rv, ev, bz, ea);
      chk("R8 error cleared on accept", ea, 0);

      // request while busy is ignored
      fr0 = frames;
      req_addr = 7'h05; req_rd = 1'b0; req_wdata = 24'h111111; req_crc_en = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (10) @(negedge clk);
      req_addr = 7'h06; req_wdata = 24'h222222; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      while (!done) @(negedge clk);
      repeat (DIV * 3) @(negedge clk);
      chk("R9 one frame only", frames - fr0, 1);
      txn(7'h06, 1'b1, 24'h0, 1'b0, rv, ev, bz, ea);
      chk("R9 ignored write left register", rv, init_val(6));
      txn(7'h05, 1'b1, 24'h0, 1'b1, rv, ev, bz, ea);
      chk("R9 accepted write landed", rv, 24'h111111);
      chk("R7 good trailer second read", ev, 0);

      chk("R3 half period length", half_bad, 0);
      chk("R3 mosi changes only on fall", mosi_bad, 0);
      chk("R5 no sclk while deselected", idle_clk_bad, 0);
      chk("R4 peripheral trailer errors", wr_crc_bad, 0);
      chk("R10 min deselect time", (gap_min >= DIV), 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule